// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Unit

This unit sits beside a serial controller and turns its level status bits into latched interrupt causes. Each status bit passes through an edge detector. A cause bit is set only on the clock edge where its status bit first reads high after reading low. A status bit that stays high sets nothing more, so software that has already handled a condition is not interrupted again until that condition drops and returns.

Software controls the unit through a small write port. A write aimed at the cause register clears every cause bit whose data bit is one. A write aimed at the mask register loads a new enable pattern. The single interrupt line is high whenever any cause bit and its enable bit are both set. The live status bits are passed through unchanged. Before it waits on the interrupt, software can read them to check whether the condition it wants already holds.

The status positions run from bit 0 to bit 12: 0 transfer finished, 1 interface idle and ready, 2 read buffer has data, 3 write buffer has room, 4 read buffer empty, 5 read buffer full, 6 write buffer empty, 7 write buffer full, 8 read underflow, 9 read overflow, 10 write underflow, 11 write overflow, 12 transfer started without an address set. The unit treats every position the same way.

Top module: `sirq_cause_unit`

## Requirements
- R1: When status bit i is sampled 1 at a clock edge and was sampled 0 at the previous edge, cause bit i is 1 after that edge.
- R2: A status bit that stays high sets no cause. A cause cleared while its status is still high stays 0 until the status falls and rises again.
- R3: A write with `reg_sel_i`=0 (cause target) clears each cause bit whose `reg_wdata_i` bit is 1 and leaves the other bits alone. All ones clears every cause.
- R4: If a rising edge and a clear hit the same cause bit on the same edge, the bit ends up set.
- R5: A write with `reg_sel_i`=1 (mask target) loads `reg_wdata_i` into the mask on that edge. A cause-target write leaves the mask unchanged.
- R6: `irq_o` is high exactly when some bit is 1 in both `cause_o` and `mask_o`. With the mask all zero, `irq_o` stays low whatever the causes are.
- R7: Cause bits latch while masked. Setting the mask bit of a pending cause raises `irq_o` right after the mask write edge.
- R8: While reset is asserted and right after it is released, cause, mask and `irq_o` are 0. A status bit that is already high during reset produces no cause after release.
- R9: `status_o` always equals `status_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | NUM_SRC | Live level status bits from the controller |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_sel_i | input | 1 | Write target: 0 clears causes, 1 loads mask |
| reg_wdata_i | input | NUM_SRC | Write data |
| cause_o | output | NUM_SRC | Latched cause register |
| mask_o | output | NUM_SRC | Mask register |
| status_o | output | NUM_SRC | Live status readback |
| irq_o | output | 1 | Interrupt request, OR of masked causes |

## Verification
On every cycle the assertions check that a detected rising edge lands in the cause register, even against a same-cycle clear. They also check that no cause bit appears without an edge, that cleared bits drop, that mask writes take effect, and that the interrupt line matches the masked causes. Other behaviour needs an ordered sequence that only the bench scenarios supply. One case holds a status high across a clear so the bit must stay dead. Another latches a cause under a zero mask and then unmasks it. A third holds status bits high through reset so that no false edge appears on release.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned SRC_COUNT = 13;

  // status bit positions as seen by software
  localparam int unsigned ST_XFER_FINISHED = 0;
  localparam int unsigned ST_IF_READY      = 1;
  localparam int unsigned ST_RBUF_AVAIL    = 2;
  localparam int unsigned ST_WBUF_ROOM     = 3;
  localparam int unsigned ST_RBUF_EMPTY    = 4;
  localparam int unsigned ST_RBUF_FULL     = 5;
  localparam int unsigned ST_WBUF_EMPTY    = 6;
  localparam int unsigned ST_WBUF_FULL     = 7;
  localparam int unsigned ST_RBUF_UNDER    = 8;
  localparam int unsigned ST_RBUF_OVER     = 9;
  localparam int unsigned ST_WBUF_UNDER    = 10;
  localparam int unsigned ST_WBUF_OVER     = 11;
  localparam int unsigned ST_NO_ADDR       = 12;

  typedef enum logic {
    TGT_CAUSE = 1'b0,
    TGT_MASK  = 1'b1
  } reg_target_e;

endpackage

// File: rtl/sirq_edge_detect.sv
module sirq_edge_detect #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);

  // The history register samples the live level on every edge, also while
  // reset is asserted. It therefore holds the current level when reset is
  // released, and a bit that is already high gives no edge.
  logic [WIDTH-1:0] hist_q;

  always_ff @(posedge clk) begin
    hist_q <= level_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign rise_o[b] = level_i[b] & ~hist_q[b];
  end

endmodule

// File: rtl/sirq_cause_bank.sv
module sirq_cause_bank #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] cause_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (set_i[b]) begin
        flag_q <= 1'b1;            // a new edge beats a clear
      end else if (clr_i[b]) begin
        flag_q <= 1'b0;
      end
    end
    assign cause_o[b] = flag_q;
  end

endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load_i) begin
      mask_q <= data_i;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/sirq_cause_unit.sv
module sirq_cause_unit
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);

  reg_target_e      tgt;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr_bits;
  logic               mask_load;

  assign tgt       = reg_target_e'(reg_sel_i);
  assign clr_bits  = (reg_wr_i && tgt == TGT_CAUSE) ? reg_wdata_i : '0;
  assign mask_load = reg_wr_i && tgt == TGT_MASK;

  sirq_edge_detect #(.WIDTH(NUM_SRC)) u_edge (
    .clk     (clk),
    .level_i (status_i),
    .rise_o  (rise)
  );

  sirq_cause_bank #(.WIDTH(NUM_SRC)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (rise),
    .clr_i   (clr_bits),
    .cause_o (cause_o)
  );

  sirq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (mask_load),
    .data_i (reg_wdata_i),
    .mask_o (mask_o)
  );

  assign irq_o    = |(cause_o & mask_o);
  assign status_o = status_i;

endmodule

// File: rtl/sirq_cause_unit_chk.sv
module sirq_cause_unit_chk #(
  parameter int unsigned NUM_SRC = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] status_i,
  input logic               reg_wr_i,
  input logic               reg_sel_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_SRC-1:0] cause_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic [NUM_SRC-1:0] status_o,
  input logic               irq_o
);

  logic [NUM_SRC-1:0] seen_q;
  logic [NUM_SRC-1:0] up;

  always_ff @(posedge clk) seen_q <= status_i;
  assign up = status_i & ~seen_q;

  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up != '0) |=> ((cause_o & $past(up)) == $past(up)));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_sel_i && ((up & reg_wdata_i) != '0))
      |=> ((cause_o & $past(up & reg_wdata_i)) == $past(up & reg_wdata_i)));

  assert_no_set_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(up)) == '0));

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_sel_i) |=> ((cause_o & $past(reg_wdata_i & ~up)) == '0));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i) |=> (mask_o == $past(reg_wdata_i)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_sel_i) |=> $stable(mask_o));

  assert_irq_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((cause_o & mask_o) != '0));

  assert_status_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_o == status_i);

endmodule

bind sirq_cause_unit sirq_cause_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_i    (status_i),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .cause_o     (cause_o),
  .mask_o      (mask_o),
  .status_o    (status_o),
  .irq_o       (irq_o)
);

// File: tb/test_sirq_cause_unit.sv
`timescale 1ns/1ps
module test_sirq_cause_unit;

  localparam int N = 13;
  localparam int NV = 17;
  // {status, wr, sel, wdata, expected cause, expected irq}
  localparam logic [41:0] VEC [NV] = '{
    {13'h0000, 1'b1, 1'b1, 13'h0001, 13'h0000, 1'b0}, // mask bit0
    {13'h0001, 1'b0, 1'b0, 13'h0000, 13'h0001, 1'b1}, // R1 rise
    {13'h0001, 1'b0, 1'b0, 13'h0000, 13'h0001, 1'b1}, // R2 level held
    {13'h0001, 1'b1, 1'b0, 13'h0001, 13'h0000, 1'b0}, // R3 clear while high
    {13'h0001, 1'b0, 1'b0, 13'h0000, 13'h0000, 1'b0}, // R2 stays clear
    {13'h0000, 1'b0, 1'b0, 13'h0000, 13'h0000, 1'b0},
    {13'h0001, 1'b1, 1'b0, 13'h1FFF, 13'h0001, 1'b1}, // R4 set wins
    {13'h0108, 1'b0, 1'b0, 13'h0000, 13'h0109, 1'b1}, // R1 two rises
    {13'h0108, 1'b1, 1'b0, 13'h0001, 13'h0108, 1'b0}, // R7 masked pending
    {13'h0108, 1'b1, 1'b1, 13'h0100, 13'h0108, 1'b1}, // R7 unmask
    {13'h0108, 1'b1, 1'b0, 13'h0008, 13'h0100, 1'b1}, // R3 partial clear
    {13'h0000, 1'b1, 1'b0, 13'h1FFF, 13'h0000, 1'b0}, // R3 all ones
    {13'h1000, 1'b0, 1'b0, 13'h0000, 13'h1000, 1'b0}, // R1 bit 12
    {13'h1000, 1'b1, 1'b1, 13'h0000, 13'h1000, 1'b0}, // R6 mask zero
    {13'h1FFF, 1'b0, 1'b0, 13'h0000, 13'h1FFF, 1'b0}, // R6 irq low
    {13'h1FFF, 1'b1, 1'b1, 13'h1FFF, 13'h1FFF, 1'b1}, // R6 irq high
    {13'h1FFF, 1'b1, 1'b0, 13'h1FFF, 13'h0000, 1'b0}  // R3 full clear
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] status_i = '0;
  logic         reg_wr_i = 1'b0;
  logic         reg_sel_i = 1'b0;
  logic [N-1:0] reg_wdata_i = '0;
  logic [N-1:0] cause_o, mask_o, status_o;
  logic         irq_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  sirq_cause_unit #(.NUM_SRC(N)) i_sirq_cause_unit (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .cause_o(cause_o),
    .mask_o(mask_o), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] st, input logic wr, input logic sel,
                      input logic [N-1:0] wd);
    @(negedge clk);
    status_i = st; reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    status_i = 13'h0005;              // high during reset
    repeat (3) @(posedge clk);
    #1;
    check("R8 cause in reset", 16'(cause_o), 16'h0);
    check("R8 irq in reset", 16'(irq_o), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 mask after release", 16'(mask_o), 16'h0);
    step(13'h0005, 1'b0, 1'b0, '0);
    step(13'h0005, 1'b0, 1'b0, '0);
    check("R8 no false edge", 16'(cause_o), 16'h0);
    check("R9 status mirror", 16'(status_o), 16'h0005);
    step(13'h0000, 1'b0, 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][41:29], VEC[i][28], VEC[i][27], VEC[i][26:14]);
      check($sformatf("vector %0d cause (R1/R2/R3/R4/R7)", i), 16'(cause_o), 16'(VEC[i][13:1]));
      check($sformatf("vector %0d irq (R6/R7)", i), 16'(irq_o), 16'(VEC[i][0]));
    end

    // R5: mask 1FFF from the table; a cause-target write must not touch it
    check("R5 mask loaded", 16'(mask_o), 16'h1FFF);
    step(13'h0000, 1'b1, 1'b0, 13'h0000);
    check("R5 mask kept", 16'(mask_o), 16'h1FFF);
    step(13'h0A5A, 1'b1, 1'b1, 13'h0003);
    check("R5 mask reload", 16'(mask_o), 16'h0003);
    check("R9 status mirror live", 16'(status_o), 16'h0A5A);
    check("R6 irq off rising bits unmasked", 16'(irq_o), 16'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule